// File: doc/BRIEF.md
# Word Reservation Monitor

This block holds one memory reservation for a core that pairs a word-sized reserving load with a conditional store. A reserving load forms its effective address from two register operands, records that the reservation is valid, with a length of four bytes and that address, and returns the fetched word zero-extended to 64 bits. A conditional store forms its own effective address and decides whether the store may go ahead. It then drives a one-cycle write strobe, the address and the data toward memory, together with a 4-bit condition result.

The store succeeds only when the reservation is valid, its length is one word and its address equals the real address supplied with the store. A valid reservation that misses but lies in the same real page as the store is flagged on its own output as an implementation-defined outcome. The block resolves that outcome as a failure. Every conditional store drops the reservation. A synchronous clear input lets the surrounding core kill the reservation for any event the block does not see.

Top module: `resv_monitor`

## Requirements
- R1: The effective address is `rb_val_i + ra_val_i`, with 0 used in place of `ra_val_i` when `ra_zero_i` is 1. A conditional store presents this address on `mem_addr_o`.
- R2: A reserving load (`req_op_i` = 1) raises `ld_valid_o` for one cycle, one clock after the request. `ld_result_o` then holds `ld_word_i` in bits 31:0 and zeros in bits 63:32.
- R3: A reserving load makes the reservation valid with a length of 4 and its effective address as the reservation address. The reservation persists across idle cycles.
- R4: A conditional store (`req_op_i` = 2) whose `real_addr_i` equals the reservation address of a valid 4-byte reservation performs the store. One clock later it drives `mem_we_o` = 4'hF for one cycle, with `mem_wdata_o` = `st_word_i`.
- R5: A conditional store against a valid reservation that does not match, but whose real address shares the page number with the reservation address, does not store. It raises `sc_impl_def_o` and reports 0 in the success bit.
- R6: A conditional store with no valid reservation, or against a valid reservation in a different page, does not store. It reports 0 in the success bit with `sc_impl_def_o` low.
- R7: For every conditional store, `cr0_valid_o` pulses one clock later. `cr0_o` is {0, 0, success, `so_i`}, most significant bit first, with the success bit at bit 1 and the overflow copy at bit 0.
- R8: Every conditional store, whether it succeeds or fails, leaves the reservation invalid. A second store to the same address therefore fails.
- R9: Reset and the synchronous clear input `rsv_kill_i` invalidate the reservation. A clear beats a reserving load in the same cycle. A store issued in the clear's cycle is still judged against the reservation held before the clear.
- R10: Page comparison uses the address bits at and above log2(`PAGE_BYTES`), which defaults to 4096. With the default, 0x3000 and 0x3FFC share a page, while 0x2FFC and 0x3000 do not.
- R11: Without a request, `mem_we_o`, `cr0_valid_o`, `ld_valid_o` and `sc_impl_def_o` stay low, and `mem_we_o` is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsv_kill_i | input | 1 | Synchronous reservation clear |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 1 = reserving load, 2 = conditional store, 0 = none |
| ra_zero_i | input | 1 | Base register field is zero; use 0 as base |
| ra_val_i | input | 64 | Base operand |
| rb_val_i | input | 64 | Index operand |
| st_word_i | input | 32 | Word to store (low half of source register) |
| ld_word_i | input | 32 | Word fetched for a reserving load |
| real_addr_i | input | 64 | Real address of the current access |
| so_i | input | 1 | Summary-overflow bit |
| mem_we_o | output | 4 | Byte write strobe |
| mem_addr_o | output | 64 | Store address |
| mem_wdata_o | output | 32 | Store data |
| cr0_valid_o | output | 1 | Condition result valid |
| cr0_o | output | 4 | Condition result |
| sc_impl_def_o | output | 1 | Same-page mismatch flag |
| ld_valid_o | output | 1 | Load result valid |
| ld_result_o | output | 64 | Zero-extended load word |

## Verification
Every result is registered once, so the write strobe, the address, the data, the condition field, the same-page flag and the load result all appear exactly one clock after the request edge. The reservation update takes effect at that same edge. The bench drives each request on a falling edge and reads the outputs on the next falling edge, which is half a cycle after the register that holds them is loaded. It then drives the next request there. Effects that persist, such as a clear or an idle gap, are observed through a later store, one request per cycle.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LRSV  = 2'd1,
    OP_SCOND = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    SC_NORSV  = 2'd0,
    SC_MATCH  = 2'd1,
    SC_SAMEPG = 2'd2,
    SC_MISS   = 2'd3
  } sc_cls_e;
endpackage

// File: rtl/resv_ea_calc.sv
module resv_ea_calc #(
  parameter int XLEN = 64
) (
  input  logic            ra_zero_i,
  input  logic [XLEN-1:0] ra_val_i,
  input  logic [XLEN-1:0] rb_val_i,
  output logic [XLEN-1:0] ea_o
);
  logic [XLEN-1:0] base;
  always_comb begin
    base = ra_zero_i ? '0 : ra_val_i;
    ea_o = base + rb_val_i;
  end
endmodule

// File: rtl/resv_store.sv
module resv_store #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             set_i,
  input  logic [XLEN-1:0]  set_addr_i,
  input  logic [LEN_W-1:0] set_len_i,
  input  logic             drop_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  addr_o,
  output logic [LEN_W-1:0] len_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      addr_o  <= set_addr_i;
      len_o   <= set_len_i;
    end else if (drop_i) begin
      valid_o <= 1'b0;
    end
  end

  // R3: a load that is not killed installs a word-length reservation
  a_r3_set_installs: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clear_i) |=> (valid_o && addr_o == $past(set_addr_i) && len_o == $past(set_len_i)));
  // R8: a store always leaves the reservation invalid
  a_r8_drop_invalidates: assert property (@(posedge clk) disable iff (rst)
    drop_i |=> !valid_o);
  // R9: an external clear invalidates the reservation
  a_r9_clear_invalidates: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !valid_o);
endmodule

// File: rtl/resv_judge.sv
module resv_judge
  import resv_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int LEN_W      = 4,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BYTES = 4096
) (
  input  logic             rsv_valid_i,
  input  logic [XLEN-1:0]  rsv_addr_i,
  input  logic [LEN_W-1:0] rsv_len_i,
  input  logic [XLEN-1:0]  real_addr_i,
  output sc_cls_e          cls_o
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(WORD_BYTES);

  logic exact_hit;
  logic same_page;

  always_comb begin
    exact_hit = (rsv_len_i == WORD_LEN) && (rsv_addr_i == real_addr_i);
    same_page = (rsv_addr_i[XLEN-1:PAGE_SHIFT] == real_addr_i[XLEN-1:PAGE_SHIFT]);
    if (!rsv_valid_i)    cls_o = SC_NORSV;
    else if (exact_hit)  cls_o = SC_MATCH;
    else if (same_page)  cls_o = SC_SAMEPG;
    else                 cls_o = SC_MISS;
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rsv_kill_i,
  input  logic                    req_valid_i,
  input  logic [1:0]              req_op_i,
  input  logic                    ra_zero_i,
  input  logic [XLEN-1:0]         ra_val_i,
  input  logic [XLEN-1:0]         rb_val_i,
  input  logic [8*WORD_BYTES-1:0] st_word_i,
  input  logic [8*WORD_BYTES-1:0] ld_word_i,
  input  logic [XLEN-1:0]         real_addr_i,
  input  logic                    so_i,
  output logic [WORD_BYTES-1:0]   mem_we_o,
  output logic [XLEN-1:0]         mem_addr_o,
  output logic [8*WORD_BYTES-1:0] mem_wdata_o,
  output logic                    cr0_valid_o,
  output logic [3:0]              cr0_o,
  output logic                    sc_impl_def_o,
  output logic                    ld_valid_o,
  output logic [XLEN-1:0]         ld_result_o
);
  localparam int LEN_W = 4;
  localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(WORD_BYTES);

  logic             is_lr, is_sc;
  logic [XLEN-1:0]  ea;
  logic             rsv_valid;
  logic [XLEN-1:0]  rsv_addr;
  logic [LEN_W-1:0] rsv_len;
  sc_cls_e          cls;
  logic             performed;

  always_comb begin
    is_lr     = req_valid_i && (op_e'(req_op_i) == OP_LRSV);
    is_sc     = req_valid_i && (op_e'(req_op_i) == OP_SCOND);
    performed = is_sc && (cls == SC_MATCH);
  end

  resv_ea_calc #(.XLEN(XLEN)) i_ea (
    .ra_zero_i (ra_zero_i),
    .ra_val_i  (ra_val_i),
    .rb_val_i  (rb_val_i),
    .ea_o      (ea)
  );

  resv_store #(.XLEN(XLEN), .LEN_W(LEN_W)) i_store (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (rsv_kill_i),
    .set_i      (is_lr),
    .set_addr_i (ea),
    .set_len_i  (WORD_LEN),
    .drop_i     (is_sc),
    .valid_o    (rsv_valid),
    .addr_o     (rsv_addr),
    .len_o      (rsv_len)
  );

  resv_judge #(
    .XLEN(XLEN), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) i_judge (
    .rsv_valid_i (rsv_valid),
    .rsv_addr_i  (rsv_addr),
    .rsv_len_i   (rsv_len),
    .real_addr_i (real_addr_i),
    .cls_o       (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we_o      <= '0;
      mem_addr_o    <= '0;
      mem_wdata_o   <= '0;
      cr0_valid_o   <= 1'b0;
      cr0_o         <= '0;
      sc_impl_def_o <= 1'b0;
      ld_valid_o    <= 1'b0;
      ld_result_o   <= '0;
    end else begin
      mem_we_o      <= performed ? '1 : '0;
      cr0_valid_o   <= is_sc;
      sc_impl_def_o <= is_sc && (cls == SC_SAMEPG);
      ld_valid_o    <= is_lr;
      if (is_sc) begin
        mem_addr_o  <= ea;
        mem_wdata_o <= st_word_i;
        cr0_o       <= {2'b00, performed, so_i};
      end
      if (is_lr) begin
        ld_result_o <= XLEN'(ld_word_i);
      end
    end
  end

  // R4: a write strobe only accompanies a reported success
  a_r4_we_with_success: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o != '0) |-> (cr0_valid_o && cr0_o[1]));
  // R11: the strobe never lasts two cycles
  a_r11_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o != '0) |=> (mem_we_o == '0));
  // R7: condition field shape
  a_r7_cr0_shape: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !$past(rst)) |=> (cr0_valid_o && cr0_o[3:2] == 2'b00 && cr0_o[0] == $past(so_i)));
  // R5: a same-page mismatch never stores
  a_r5_impl_def_no_store: assert property (@(posedge clk) disable iff (rst)
    sc_impl_def_o |-> (cr0_valid_o && !cr0_o[1] && mem_we_o == '0));
  // R2: the load result upper half is zero
  a_r2_ld_zero_ext: assert property (@(posedge clk) disable iff (rst)
    ld_valid_o |-> (ld_result_o[XLEN-1:8*WORD_BYTES] == '0));
  // R6: without a reservation a store cannot succeed
  a_r6_no_rsv_no_store: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !rsv_valid) |=> (mem_we_o == '0));
endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
  logic        clk = 1'b0;
  logic        rst;
  logic        rsv_kill_i;
  logic        req_valid_i;
  logic [1:0]  req_op_i;
  logic        ra_zero_i;
  logic [63:0] ra_val_i, rb_val_i, real_addr_i;
  logic [31:0] st_word_i, ld_word_i;
  logic        so_i;
  logic [3:0]  mem_we_o;
  logic [63:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        cr0_valid_o;
  logic [3:0]  cr0_o;
  logic        sc_impl_def_o;
  logic        ld_valid_o;
  logic [63:0] ld_result_o;

  always #5 clk = ~clk;

  resv_monitor i_resv_monitor (
    .clk(clk), .rst(rst), .rsv_kill_i(rsv_kill_i), .req_valid_i(req_valid_i),
    .req_op_i(req_op_i), .ra_zero_i(ra_zero_i), .ra_val_i(ra_val_i),
    .rb_val_i(rb_val_i), .st_word_i(st_word_i), .ld_word_i(ld_word_i),
    .real_addr_i(real_addr_i), .so_i(so_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .cr0_valid_o(cr0_valid_o),
    .cr0_o(cr0_o), .sc_impl_def_o(sc_impl_def_o), .ld_valid_o(ld_valid_o),
    .ld_result_o(ld_result_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        raz;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [31:0] rl;
    logic        so;
    logic        we;
    logic [3:0]  cr0;
    logic        undef;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 1'b0, 32'h100,  32'h10,   32'h110,  1'b0, 1'b0, 4'b0000, 1'b0}, // R6 no reservation
    '{2'd2, 1'b0, 32'h100,  32'h10,   32'h110,  1'b1, 1'b0, 4'b0001, 1'b0}, // R7 overflow copy
    '{2'd1, 1'b0, 32'h1000, 32'h20,   32'h1020, 1'b0, 1'b0, 4'b0000, 1'b0}, // R3 load at 0x1020
    '{2'd2, 1'b1, 32'hdead, 32'h1020, 32'h1020, 1'b1, 1'b1, 4'b0011, 1'b0}, // R1 R4 zero base
    '{2'd2, 1'b1, 32'h0,    32'h1020, 32'h1020, 1'b0, 1'b0, 4'b0000, 1'b0}, // R8 second store
    '{2'd1, 1'b0, 32'h2000, 32'h40,   32'h2040, 1'b0, 1'b0, 4'b0000, 1'b0}, // R3 load 0x2040
    '{2'd2, 1'b1, 32'h0,    32'h2080, 32'h2080, 1'b1, 1'b0, 4'b0001, 1'b1}, // R5 same page
    '{2'd2, 1'b1, 32'h0,    32'h2040, 32'h2040, 1'b0, 1'b0, 4'b0000, 1'b0}, // R8 dropped
    '{2'd1, 1'b1, 32'h0,    32'h2ffc, 32'h2ffc, 1'b0, 1'b0, 4'b0000, 1'b0}, // R10 load 0x2ffc
    '{2'd2, 1'b1, 32'h0,    32'h3000, 32'h3000, 1'b0, 1'b0, 4'b0000, 1'b0}, // R10 R6 other page
    '{2'd1, 1'b1, 32'h0,    32'h3000, 32'h3000, 1'b0, 1'b0, 4'b0000, 1'b0}, // R10 load 0x3000
    '{2'd2, 1'b1, 32'h0,    32'h3ffc, 32'h3ffc, 1'b0, 1'b0, 4'b0000, 1'b1}, // R10 R5 page end
    '{2'd1, 1'b0, 32'h3000, 32'h1000, 32'h4000, 1'b0, 1'b0, 4'b0000, 1'b0}, // R3 load 0x4000
    '{2'd2, 1'b0, 32'h8000, 32'h1000, 32'h4000, 1'b1, 1'b1, 4'b0011, 1'b0}  // R4 real match, ea 0x9000
  };

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic raz, input logic [63:0] ra,
                       input logic [63:0] rb, input logic [63:0] rl, input logic so,
                       input logic [31:0] stw, input logic [31:0] ldw, input logic kill);
    req_valid_i = (op != 2'd0);
    req_op_i    = op;
    ra_zero_i   = raz;
    ra_val_i    = ra;
    rb_val_i    = rb;
    real_addr_i = rl;
    so_i        = so;
    st_word_i   = stw;
    ld_word_i   = ldw;
    rsv_kill_i  = kill;
  endtask

  task automatic idle();
    drive(2'd0, 1'b0, 64'h0, 64'h0, 64'h0, 1'b0, 32'h0, 32'h0, 1'b0);
  endtask

  // one store at a word address; check outcome one clock later
  task automatic store_chk(input string req, input logic [63:0] a, input logic kill, input logic exp_ok);
    drive(2'd2, 1'b1, 64'h0, a, a, 1'b0, 32'h600d_f00d, 32'h0, kill);
    @(negedge clk);
    chk(req, {63'h0, cr0_o[1]}, {63'h0, exp_ok});
    chk(req, {60'h0, mem_we_o}, exp_ok ? 64'hF : 64'h0);
  endtask

  task automatic load(input logic [63:0] a, input logic kill);
    drive(2'd1, 1'b1, 64'h0, a, a, 1'b0, 32'h0, 32'h1234_5678, kill);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset we", {60'h0, mem_we_o}, 64'h0);
    chk("R9 reset cr0v", {63'h0, cr0_valid_o}, 64'h0);
    chk("R9 reset ldv", {63'h0, ld_valid_o}, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] ea;
      logic [31:0] stw, ldw;
      vec_t v;
      v   = TBL[i];
      stw = 32'h5700_0000 + 32'(i);
      ldw = 32'hC0DE_0000 + 32'(i);
      ea  = 64'(v.rb) + (v.raz ? 64'h0 : 64'(v.ra));
      drive(v.op, v.raz, 64'(v.ra), 64'(v.rb), 64'(v.rl), v.so, stw, ldw, 1'b0);
      @(negedge clk);
      if (v.op == 2'd2) begin
        chk($sformatf("R7 cr0 vec%0d", i), {60'h0, cr0_o}, {60'h0, v.cr0});
        chk($sformatf("R4 we vec%0d", i), {60'h0, mem_we_o}, v.we ? 64'hF : 64'h0);
        chk($sformatf("R5 flag vec%0d", i), {63'h0, sc_impl_def_o}, {63'h0, v.undef});
        chk($sformatf("R1 addr vec%0d", i), mem_addr_o, ea);
        if (v.we) chk($sformatf("R4 wdata vec%0d", i), {32'h0, mem_wdata_o}, {32'h0, stw});
      end else begin
        chk($sformatf("R2 ldv vec%0d", i), {63'h0, ld_valid_o}, 64'h1);
        chk($sformatf("R2 ldres vec%0d", i), ld_result_o, {32'h0, ldw});
        chk($sformatf("R11 no cr0 vec%0d", i), {63'h0, cr0_valid_o}, 64'h0);
      end
    end
    idle();
    @(negedge clk);
    // R11: quiet outputs after an idle cycle
    chk("R11 idle we", {60'h0, mem_we_o}, 64'h0);
    chk("R11 idle cr0v", {63'h0, cr0_valid_o}, 64'h0);
    chk("R11 idle ldv", {63'h0, ld_valid_o}, 64'h0);
    chk("R11 idle flag", {63'h0, sc_impl_def_o}, 64'h0);

    // R3: reservation survives idle cycles
    load(64'h5000, 1'b0);
    idle();
    repeat (3) @(negedge clk);
    store_chk("R3 persists", 64'h5000, 1'b0, 1'b1);

    // R9: standalone clear kills the reservation
    load(64'h6000, 1'b0);
    drive(2'd0, 1'b0, 64'h0, 64'h0, 64'h0, 1'b0, 32'h0, 32'h0, 1'b1);
    @(negedge clk);
    store_chk("R9 clear", 64'h6000, 1'b0, 1'b0);

    // R9: clear beats a load in the same cycle
    load(64'h7000, 1'b1);
    store_chk("R9 clear over load", 64'h7000, 1'b0, 1'b0);

    // R9: a store in the clear's cycle uses the held reservation
    load(64'h7100, 1'b0);
    store_chk("R9 store with clear", 64'h7100, 1'b1, 1'b1);

    // R9: reset drops the reservation
    load(64'h7200, 1'b0);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    store_chk("R9 reset drop", 64'h7200, 1'b0, 1'b0);

    idle();
    @(negedge clk);
    finish_run();
  end
endmodule